// File: doc/BRIEF.md
# Continuous-Read Mode Tracker for a Serial NOR Flash Front End

This block sits at the device side of a serial NOR flash command decoder. It watches chip select, the serial clock and up to four I/O lines. In normal operation it collects an 8-bit command on lane 0 and reports it. When that command is a dual-lane or quad-lane I/O fast read, it collects the 24-bit address on the matching number of lanes. It then collects the mode byte that follows the address.

A mode byte whose upper nibble is binary 1010 puts the part into continuous-read mode. The next chip-select cycle then carries no command byte. Its first serial clocks go straight into the address shifter, using the lane width of the read that set the mode. There is no dedicated reset pin. The mode therefore persists across any number of transactions. While it holds, standard commands are not decoded. Two things release it: a mode byte with a different upper nibble, or an all-ones escape sequence of a length that depends on the lane width.

The logic is clocked by a fast system clock. It oversamples the serial clock and acts on each rising serial edge. It accepts either clock idle level at the moment chip select falls. The system reset only initialises the logic at power-up. Memory access, dummy cycles, data return and all other commands belong to other blocks.

Top module: `cmTracker`

## Requirements
- R1: After reset, contMode, contQuad, opValid, opSkip and addrValid are all 0.
- R2: With contMode clear, the first 8 rising serial edges after chip select falls shift sio[0] in MSB first. The resulting byte appears on opCode with opValid high for exactly one clock.
- R3: Command 0xEB selects quad lanes and command 0xBB selects dual lanes. The 24-bit address follows: on quad lanes, 6 edges with sio[3] as the most significant bit of each nibble; on dual lanes, 12 edges with sio[1] above sio[0]. The address appears on addr with addrValid high for one clock.
- R4: The 8-bit mode byte follows the address, MSB first, over 2 quad edges or 4 dual edges. If its bits 7..4 equal 4'b1010, contMode becomes 1 when chip select rises, and contQuad records the lane width (1 = quad).
- R5: A completed mode byte with any other upper nibble leaves contMode at 0 when chip select rises.
- R6: When chip select falls with contMode set, opSkip pulses for one clock and the following edges are taken as address bits at the recorded lane width.
- R7: While contMode is set, no command byte is decoded: opValid stays low for the whole transaction.
- R8: In quad continuous mode, 8 consecutive rising edges with sio[3:0] all high clear contMode at the 8th edge.
- R9: In dual continuous mode, 16 consecutive rising edges with sio[1:0] both high clear contMode at the 16th edge. Fewer than 16 such edges do not clear it, and sio[3:2] are ignored.
- R10: If chip select rises before the mode byte or the escape sequence is complete, contMode and contQuad keep their values.
- R11: Both clock idle levels are supported: the serial clock may be low (mode 0) or high (mode 3) when chip select falls.
- R12: A command other than 0xEB or 0xBB is reported on opCode. The rest of its transaction produces no addrValid and leaves contMode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial interface |
| rstN | input | 1 | Active-low power-up initialisation of the logic |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select from the host |
| sio | input | 4 | Serial data lanes, lane 0 carries command bits |
| opValid | output | 1 | One-clock strobe: a command byte was decoded |
| opCode | output | 8 | Last decoded command byte |
| opSkip | output | 1 | One-clock strobe: transaction began without a command |
| addrValid | output | 1 | One-clock strobe: an address was collected |
| addr | output | 24 | Last collected address |
| contMode | output | 1 | Continuous-read mode flag |
| contQuad | output | 1 | Lane width recorded with the flag, 1 = quad |

## Verification
Each result becomes visible a fixed number of clocks after its stimulus. opValid and addrValid appear one system clock after the clock edge that sees the completing rising serial edge. The escape sequence clears contMode on that same boundary. opSkip appears one clock after the edge that sees chip select low. contMode is set one clock after the edge that sees chip select high. The bench holds each serial level for two system clocks and counts the strobes at falling system-clock edges across the whole transaction. It checks the flag only after chip select has been high for three clocks, or two clocks after the rising edge that completes an escape sequence, so every check samples well after its result is due.

// File: rtl/cmTrackPkg.sv
package cmTrackPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_ADDR,
    PH_MODE,
    PH_REST
  } phaseT;

  // strobes from the control FSM to the shift datapath
  typedef struct packed {
    logic clrCnt;    // restart the per-phase edge counter
    logic clrOnes;   // restart the all-ones run tracker
    logic sample;    // a rising serial edge inside a selected transaction
    logic laneQuad;  // 1: four lanes per edge, 0: two lanes per edge
    logic toOp;      // shift lane 0 into the command shifter
    logic toAddr;    // shift lanes into the address shifter
    logic toMode;    // shift lanes into the mode shifter
    logic opDone;    // latch the command and pulse its strobe
    logic addrDone;  // latch the address and pulse its strobe
  } dpStrobeT;

endpackage

// File: rtl/cmLaneShift.sv
module cmLaneShift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         quad,
  input  logic [3:0]   sio,
  output logic [W-1:0] nxt
);

  logic [W-1:0] q;

  // shift by the lane count; the newest lanes land in the low bits
  always_comb begin
    if (quad) nxt = (q << 4) | W'(sio);
    else      nxt = (q << 2) | W'(sio[1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= '0;
    else if (en) q <= nxt;
  end

endmodule

// File: rtl/cmDatapath.sv
module cmDatapath
  import cmTrackPkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int OP_BITS   = 8,
  parameter int MODE_BITS = 8,
  parameter int CNT_W     = 5,
  parameter int ONES_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobeT             strb,
  input  logic [3:0]           sio,
  output logic [CNT_W-1:0]     phCnt,
  output logic [ONES_W-1:0]    onesCnt,
  output logic                 onesOk,
  output logic                 laneOnes,
  output logic [OP_BITS-1:0]   opNext,
  output logic [MODE_BITS-1:0] modeNext,
  output logic [OP_BITS-1:0]   opCode,
  output logic                 opValid,
  output logic [ADDR_BITS-1:0] addr,
  output logic                 addrValid
);

  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(2 * MODE_BITS);

  logic [OP_BITS-1:0]   opSh;
  logic [ADDR_BITS-1:0] addrNext;

  assign opNext   = (opSh << 1) | OP_BITS'(sio[0]);
  assign laneOnes = strb.laneQuad ? (&sio) : (&sio[1:0]);

  cmLaneShift #(.W(ADDR_BITS)) addrShift (
    .clk (clk),
    .rstN(rstN),
    .en  (strb.toAddr),
    .quad(strb.laneQuad),
    .sio (sio),
    .nxt (addrNext)
  );

  cmLaneShift #(.W(MODE_BITS)) modeShift (
    .clk (clk),
    .rstN(rstN),
    .en  (strb.toMode),
    .quad(strb.laneQuad),
    .sio (sio),
    .nxt (modeNext)
  );

  // per-phase edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phCnt <= '0;
    else if (strb.clrCnt)  phCnt <= '0;
    else if (strb.sample)  phCnt <= phCnt + 1'b1;
  end

  // run of all-ones edges since chip select fell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
      onesOk  <= 1'b1;
    end else if (strb.clrOnes) begin
      onesCnt <= '0;
      onesOk  <= 1'b1;
    end else if (strb.sample) begin
      if (!laneOnes)                onesOk  <= 1'b0;
      else if (onesCnt != ONES_MAX) onesCnt <= onesCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           opSh <= '0;
    else if (strb.toOp)  opSh <= opNext;
  end

  // result registers with one-clock strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCode    <= '0;
      opValid   <= 1'b0;
      addr      <= '0;
      addrValid <= 1'b0;
    end else begin
      opValid   <= strb.opDone;
      addrValid <= strb.addrDone;
      if (strb.opDone)   opCode <= opNext;
      if (strb.addrDone) addr   <= addrNext;
    end
  end

  AST_OPVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid); // R2

  AST_ADDRVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid); // R3

  AST_ONE_SHIFT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.toOp, strb.toAddr, strb.toMode})); // R3

endmodule

// File: rtl/cmControl.sv
module cmControl
  import cmTrackPkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int OP_BITS   = 8,
  parameter int MODE_BITS = 8,
  parameter int CNT_W     = 5,
  parameter int ONES_W    = 5,
  parameter logic [OP_BITS-1:0] QUAD_OP = 8'hEB,
  parameter logic [OP_BITS-1:0] DUAL_OP = 8'hBB,
  parameter logic [3:0] MODE_KEY = 4'hA
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic [CNT_W-1:0]     phCnt,
  input  logic [ONES_W-1:0]    onesCnt,
  input  logic                 onesOk,
  input  logic                 laneOnes,
  input  logic [OP_BITS-1:0]   opNext,
  input  logic [MODE_BITS-1:0] modeNext,
  output dpStrobeT             strb,
  output logic                 opSkip,
  output logic                 contMode,
  output logic                 contQuad
);

  localparam logic [CNT_W-1:0]  OP_LAST  = CNT_W'(OP_BITS - 1);
  localparam logic [CNT_W-1:0]  QA_LAST  = CNT_W'(ADDR_BITS / 4 - 1);
  localparam logic [CNT_W-1:0]  DA_LAST  = CNT_W'(ADDR_BITS / 2 - 1);
  localparam logic [CNT_W-1:0]  QM_LAST  = CNT_W'(MODE_BITS / 4 - 1);
  localparam logic [CNT_W-1:0]  DM_LAST  = CNT_W'(MODE_BITS / 2 - 1);
  localparam logic [ONES_W-1:0] QR_LAST  = ONES_W'(MODE_BITS - 1);
  localparam logic [ONES_W-1:0] DR_LAST  = ONES_W'(2 * MODE_BITS - 1);
  localparam logic [MODE_BITS-1:0] KEY_W = MODE_BITS'(MODE_KEY);

  phaseT phase, phaseNx;
  logic  sclkPrev, csPrev;
  logic  xferQuad, quadNx;
  logic  flag, flagQuad;
  logic  modeSeen, modeSeenNx;
  logic  modeHit, modeHitNx;
  logic  resetHit;
  logic  csFall, csRise, sckRise, resetFire;
  logic [CNT_W-1:0]  addrLast, modeLast;
  logic [ONES_W-1:0] rstLast;

  assign csFall   = !csN && csPrev;
  assign csRise   = csN && !csPrev;
  assign sckRise  = sclk && !sclkPrev && !csN && !csFall;
  assign addrLast = xferQuad ? QA_LAST : DA_LAST;
  assign modeLast = xferQuad ? QM_LAST : DM_LAST;
  assign rstLast  = flagQuad ? QR_LAST : DR_LAST;

  // escape sequence: an unbroken run of all-ones edges of the mode's length
  assign resetFire = sckRise && flag && onesOk && laneOnes && (onesCnt == rstLast);

  always_comb begin
    strb          = '0;
    strb.laneQuad = xferQuad;
    strb.sample   = sckRise;
    strb.clrCnt   = csFall;
    strb.clrOnes  = csFall;
    phaseNx       = phase;
    quadNx        = xferQuad;
    modeSeenNx    = modeSeen;
    modeHitNx     = modeHit;
    if (csFall) begin
      modeSeenNx = 1'b0;
      if (flag) begin
        phaseNx = PH_ADDR;
        quadNx  = flagQuad;
      end else begin
        phaseNx = PH_OPCODE;
      end
    end else if (csN) begin
      phaseNx = PH_IDLE;
    end else if (sckRise) begin
      unique case (phase)
        PH_OPCODE: begin
          strb.toOp = 1'b1;
          if (phCnt == OP_LAST) begin
            strb.opDone = 1'b1;
            strb.clrCnt = 1'b1;
            if (opNext == QUAD_OP) begin
              phaseNx = PH_ADDR;
              quadNx  = 1'b1;
            end else if (opNext == DUAL_OP) begin
              phaseNx = PH_ADDR;
              quadNx  = 1'b0;
            end else begin
              phaseNx = PH_REST;
            end
          end
        end
        PH_ADDR: begin
          strb.toAddr = 1'b1;
          if (phCnt == addrLast) begin
            strb.addrDone = 1'b1;
            strb.clrCnt   = 1'b1;
            phaseNx       = PH_MODE;
          end
        end
        PH_MODE: begin
          strb.toMode = 1'b1;
          if (phCnt == modeLast) begin
            strb.clrCnt = 1'b1;
            modeSeenNx  = 1'b1;
            modeHitNx   = ((modeNext >> (MODE_BITS - 4)) == KEY_W);
            phaseNx     = PH_REST;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
      phase    <= PH_IDLE;
      xferQuad <= 1'b0;
      modeSeen <= 1'b0;
      modeHit  <= 1'b0;
      opSkip   <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      csPrev   <= csN;
      phase    <= phaseNx;
      xferQuad <= quadNx;
      modeSeen <= modeSeenNx;
      modeHit  <= modeHitNx;
      opSkip   <= csFall && flag;
    end
  end

  // mode flag: no dedicated reset pin, only the mode byte or the escape run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag     <= 1'b0;
      flagQuad <= 1'b0;
      resetHit <= 1'b0;
    end else begin
      if (csFall) resetHit <= 1'b0;
      if (resetFire) begin
        flag     <= 1'b0;
        resetHit <= 1'b1;
      end else if (csRise && modeSeen && !resetHit) begin
        flag     <= modeHit;
        flagQuad <= xferQuad;
      end
    end
  end

  assign contMode = flag;
  assign contQuad = flagQuad;

  AST_FLAG_RISES_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(csN)); // R4

  AST_FLAG_HOLDS_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> !$rose(flag)); // R10

  AST_SKIP_ONLY_IN_CONT: assert property (@(posedge clk) disable iff (!rstN)
    opSkip |-> $past(flag)); // R6

  AST_NO_OPCODE_IN_CONT: assert property (@(posedge clk) disable iff (!rstN)
    strb.opDone |-> !flag); // R7

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (phase == PH_IDLE)); // R10

endmodule

// File: rtl/cmTracker.sv
module cmTracker
  import cmTrackPkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int OP_BITS   = 8,
  parameter int MODE_BITS = 8,
  parameter logic [OP_BITS-1:0] QUAD_OP = 8'hEB,
  parameter logic [OP_BITS-1:0] DUAL_OP = 8'hBB,
  parameter logic [3:0] MODE_KEY = 4'hA
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic [3:0]           sio,
  output logic                 opValid,
  output logic [OP_BITS-1:0]   opCode,
  output logic                 opSkip,
  output logic                 addrValid,
  output logic [ADDR_BITS-1:0] addr,
  output logic                 contMode,
  output logic                 contQuad
);

  localparam int CNT_W  = $clog2(ADDR_BITS + OP_BITS);
  localparam int ONES_W = $clog2(2 * MODE_BITS + 1);

  dpStrobeT             strb;
  logic [CNT_W-1:0]     phCnt;
  logic [ONES_W-1:0]    onesCnt;
  logic                 onesOk;
  logic                 laneOnes;
  logic [OP_BITS-1:0]   opNext;
  logic [MODE_BITS-1:0] modeNext;

  cmControl #(
    .ADDR_BITS(ADDR_BITS), .OP_BITS(OP_BITS), .MODE_BITS(MODE_BITS),
    .CNT_W(CNT_W), .ONES_W(ONES_W),
    .QUAD_OP(QUAD_OP), .DUAL_OP(DUAL_OP), .MODE_KEY(MODE_KEY)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .phCnt   (phCnt),
    .onesCnt (onesCnt),
    .onesOk  (onesOk),
    .laneOnes(laneOnes),
    .opNext  (opNext),
    .modeNext(modeNext),
    .strb    (strb),
    .opSkip  (opSkip),
    .contMode(contMode),
    .contQuad(contQuad)
  );

  cmDatapath #(
    .ADDR_BITS(ADDR_BITS), .OP_BITS(OP_BITS), .MODE_BITS(MODE_BITS),
    .CNT_W(CNT_W), .ONES_W(ONES_W)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sio      (sio),
    .phCnt    (phCnt),
    .onesCnt  (onesCnt),
    .onesOk   (onesOk),
    .laneOnes (laneOnes),
    .opNext   (opNext),
    .modeNext (modeNext),
    .opCode   (opCode),
    .opValid  (opValid),
    .addr     (addr),
    .addrValid(addrValid)
  );

endmodule

// File: tb/tb_cmTracker.sv
module tb_cmTracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        csN = 1'b1;
  logic [3:0]  sio = 4'h0;
  logic        opValid, opSkip, addrValid, contMode, contQuad;
  logic [7:0]  opCode;
  logic [23:0] addr;

  always #5 clk = ~clk;

  cmTracker dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sio(sio),
    .opValid(opValid), .opCode(opCode), .opSkip(opSkip),
    .addrValid(addrValid), .addr(addr),
    .contMode(contMode), .contQuad(contQuad)
  );

  int nChecks = 0;
  int nFail = 0;
  int nOp, nAddr, nSkip;
  logic [7:0]  lastOp;
  logic [23:0] lastAddr;
  bit expFlag = 1'b0;
  bit expQuad = 1'b0;
  bit spiMode3 = 1'b0;
  bit finished = 1'b0;

  // strobe monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (opValid)   begin nOp++;   lastOp = opCode;  end
      if (addrValid) begin nAddr++; lastAddr = addr;  end
      if (opSkip)    nSkip++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int needOnes(input bit q);
    return q ? 8 : 16;
  endfunction

  task automatic clk1(input logic [3:0] lanes);
    @(negedge clk);
    sio  = lanes;
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk);
    sclk = spiMode3;
    repeat (2) @(negedge clk);
    nOp = 0; nAddr = 0; nSkip = 0;
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk);
    if (!spiMode3) sclk = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendOp(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) clk1({3'($urandom), op[i]});
  endtask

  task automatic sendLanes(input bit q, input int nEdges, input logic [23:0] val);
    for (int i = nEdges - 1; i >= 0; i--) begin
      if (q) clk1(val[4*i +: 4]);
      else   clk1({2'($urandom), val[2*i +: 2]});
    end
  endtask

  // full dual or quad read; the recorded width wins when the mode is set
  task automatic doRead(input bit quad, input logic [23:0] a, input logic [7:0] m);
    bit cont = expFlag;
    bit q = cont ? expQuad : quad;
    csLow();
    if (!cont) sendOp(q ? 8'hEB : 8'hBB);
    sendLanes(q, q ? 6 : 12, a);
    sendLanes(q, q ? 2 : 4, {16'h0, m});
    csHigh();
    chk(nSkip == (cont ? 1 : 0), "R6", "skip strobes", nSkip, cont ? 1 : 0);
    chk(nOp == (cont ? 0 : 1), cont ? "R7" : "R2", "command strobes", nOp, cont ? 0 : 1);
    if (!cont) chk(lastOp == (q ? 8'hEB : 8'hBB), "R2", "command byte", lastOp, q ? 8'hEB : 8'hBB);
    chk(nAddr == 1 && lastAddr == a, cont ? "R6" : "R3", "address", lastAddr, a);
    expFlag = (m[7:4] == 4'hA);
    expQuad = expFlag ? q : expQuad;
    chk(contMode == expFlag, expFlag ? "R4" : "R5", "mode flag", contMode, expFlag);
    if (expFlag) chk(contQuad == expQuad, "R4", "lane width", contQuad, expQuad);
  endtask

  // run of all-ones edges at the active lane width
  task automatic doOnes(input bit quad, input int nEdges);
    bit cont = expFlag;
    bit q = cont ? expQuad : quad;
    int need = needOnes(q);
    csLow();
    for (int k = 1; k <= nEdges; k++) begin
      clk1(q ? 4'hF : {2'($urandom), 2'b11});
      if (cont && k == need)
        chk(contMode == 1'b0, q ? "R8" : "R9", "flag at final escape edge", contMode, 0);
    end
    csHigh();
    if (cont) begin
      chk(nOp == 0, "R7", "command strobes in mode", nOp, 0);
      if (nEdges >= need) expFlag = 1'b0;
      chk(contMode == expFlag, nEdges >= need ? (q ? "R8" : "R9") : "R10",
          "flag after escape run", contMode, expFlag);
    end else begin
      chk(nOp == (nEdges >= 8 ? 1 : 0), "R2", "command strobes", nOp, nEdges >= 8 ? 1 : 0);
      if (nEdges >= 8) chk(lastOp == 8'hFF, "R2", "command byte", lastOp, 8'hFF);
      chk(contMode == 1'b0, "R12", "flag after unknown command", contMode, 0);
    end
  endtask

  // chip select rises before the mode byte completes
  task automatic doAbort(input bit quad, input int nEdges);
    bit cont = expFlag;
    bit q = cont ? expQuad : quad;
    bit qBefore = contQuad;
    csLow();
    if (!cont) sendOp(q ? 8'hEB : 8'hBB);
    for (int k = 0; k < nEdges; k++) clk1(4'($urandom));
    csHigh();
    chk(contMode == expFlag, "R10", "flag after early deselect", contMode, expFlag);
    chk(contQuad == qBefore, "R10", "width after early deselect", contQuad, qBefore);
  endtask

  task automatic doOther(input logic [7:0] op, input int nEdges);
    csLow();
    sendOp(op);
    for (int k = 0; k < nEdges; k++) clk1(4'($urandom));
    csHigh();
    chk(nOp == 1 && lastOp == op, "R12", "command byte", lastOp, op);
    chk(nAddr == 0, "R12", "address strobes", nAddr, 0);
    chk(contMode == expFlag, "R12", "flag", contMode, expFlag);
  endtask

  // standard command bits sent while dual mode is set
  task automatic doStdInDual(input logic [7:0] op);
    csLow();
    for (int i = 7; i >= 0; i--) clk1({3'b000, op[i]});
    csHigh();
    chk(nOp == 0, "R7", "command strobes in mode", nOp, 0);
    chk(contMode == 1'b1, "R7", "flag after ignored command", contMode, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    chk(contMode == 0 && contQuad == 0, "R1", "flags in reset", {contMode, contQuad}, 0);
    chk(opValid == 0 && opSkip == 0 && addrValid == 0, "R1", "strobes in reset",
        {opValid, opSkip, addrValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(contMode == 0 && opValid == 0 && opSkip == 0 && addrValid == 0, "R1",
        "outputs after reset", {contMode, opValid, opSkip, addrValid}, 0);

    // directed corner cases
    spiMode3 = 1'b0; doRead(1'b1, 24'h12A5C3, 8'hA5);   // R3 R4 quad entry, mode 0
    spiMode3 = 1'b1; doRead(1'b1, 24'h00FF10, 8'hAF);   // R6 R11 opcode-less, mode 3
    spiMode3 = 1'b0; doOnes(1'b1, 8);                   // R8
    spiMode3 = 1'b1; doRead(1'b0, 24'h5A5A5A, 8'hA0);   // R3 R4 dual entry, mode 3
    doStdInDual(8'h9F);                                 // R7
    spiMode3 = 1'b0; doOnes(1'b0, 8);                   // R9 too short
    doOnes(1'b0, 15);                                   // R9 one short
    doAbort(1'b0, 13);                                  // R10 mid mode byte
    doOnes(1'b0, 16);                                   // R9
    doOther(8'h03, 20);                                 // R12
    doRead(1'b1, 24'hFEDCBA, 8'h5A);                    // R5 wrong nibble
    doRead(1'b0, 24'h000001, 8'hA3);
    spiMode3 = 1'b1; doRead(1'b0, 24'h800000, 8'h3C);   // R5 leaves mode
    doOnes(1'b1, 9);                                    // R2 all-ones as command

    // constrained random mix
    for (int it = 0; it < 70; it++) begin
      int sel = int'($urandom % 10);
      bit q = 1'($urandom);
      spiMode3 = 1'($urandom);
      if (sel < 6) begin
        logic [7:0] m = 8'($urandom);
        if ($urandom % 2 == 0) m[7:4] = 4'hA;
        doRead(q, 24'($urandom), m);
      end else if (sel < 8) begin
        doOnes(q, 4 + int'($urandom % 15));
      end else if (sel == 8) begin
        bit qa = expFlag ? expQuad : q;
        doAbort(q, int'($urandom % (qa ? 8 : 16)));
      end else begin
        logic [7:0] op = 8'($urandom);
        if (op == 8'hEB || op == 8'hBB) op = 8'h05;
        if (!expFlag) doOther(op, int'($urandom % 20));
        else doRead(q, 24'($urandom), 8'hA1);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule